// File: doc/BRIEF.md
# Bank-Set Migration Controller

This block controls one bank set of a multibanked second-level cache. The four ways of every set sit in four banks. Each bank is farther from the controller than the one before it. Bank `i` answers a probe `2+2*i` cycles after it receives it, so bank 0 answers after 2 cycles and bank 3 after 8. The four bank arrays are instantiated inside the block. Lines move between them under controller command, and the ports carry only the request, the response and the next-level fetch.

For each accepted request the controller locates the line with a search policy that a static 2-bit input selects. Three policies are available:
- A serial walk outward from the nearest bank.
- A broadcast to all four banks at once.
- A hybrid that probes the two nearest banks together and then walks the remaining two in order.

When the line is found in bank `h>0`, it trades places with the line held in bank `h-1`. A line that is used repeatedly therefore drifts toward the fast end one step per hit. On a miss, a read fetches the line from the next level. Both a read miss and a write miss place the new line in the farthest bank. The line that held that slot is discarded and is not moved to another bank.

The FSM states are:
- `ST_IDLE`: ready for a request.
- `ST_SEARCH`: probes are outstanding and there is no verdict yet.
- `ST_DRAIN`: a hit is known, but slower probes are still returning.
- `ST_FETCH`: a next-level request is offered.
- `ST_AWAIT`: waiting for the next-level data.
- `ST_INSERT`: writing the new line into bank 3.
- `ST_SWAP_A`: writing the displaced closer line into the hit bank.
- `ST_PROMOTE`: writing the hit line into the closer bank, or back into bank 0 for a write hit there.

The transitions are:
- IDLE→SEARCH on accept.
- SEARCH→DRAIN on a hit with probes still pending.
- SEARCH or DRAIN→SWAP_A when the hit bank is above 0.
- SEARCH or DRAIN→PROMOTE for a write hit in bank 0.
- SEARCH or DRAIN→IDLE for a read hit in bank 0.
- SEARCH→FETCH on a read miss.
- SEARCH→INSERT on a write miss.
- FETCH→AWAIT when the next level accepts.
- AWAIT→INSERT when the data returns.
- INSERT→IDLE.
- SWAP_A→PROMOTE.
- PROMOTE→IDLE.

Top module: `bankset_migrator`

## Requirements
- R1: With `cfg_locate` = 0 or 3 (serial), exactly one bank is probed at a time, starting at bank 0. A hit in bank h reports `rsp_lat` = (h+1)(h+2), which is 2, 6, 12 or 20 cycles. A miss is resolved after 20 cycles.
- R2: With `cfg_locate` = 1 (broadcast), all four banks are probed in the acceptance cycle. A hit in bank h reports `rsp_lat` = 2+2h, and a miss is resolved after 8 cycles.
- R3: With `cfg_locate` = 2 (hybrid), banks 0 and 1 are probed together, then bank 2, then bank 3. Hits report `rsp_lat` 2, 4, 10 or 18, and a miss is resolved after 18 cycles.
- R4: A hit in bank h>0 exchanges the line with the line in bank h-1. A later access to the same address is then served from bank h-1, and the line that was displaced is found in bank h.
- R5: A hit in bank 0 leaves the line in bank 0.
- R6: A read miss issues exactly one next-level request carrying the request address. It then answers with `rsp_hit`=0, `rsp_bank`=3 and the returned data, and the line is thereafter found in bank 3.
- R7: An insertion discards the previous occupant of bank 3 in that set, and a later access to that address misses. Banks 0 to 2 are not written by an insertion.
- R8: `req_ready` stays low from acceptance until the response. It stays low for exactly 2 further cycles when a swap follows the response. It is high in the response cycle after a read hit in bank 0 (serial) or after a miss.
- R9: A write hit returns the write data and stores it in the promoted line. A write miss installs the write data in bank 3 without any next-level request.
- R10: `req_addr[1:0]` selects the set and `req_addr[7:2]` is the tag. Lines of one set are never found by a request to another set.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `nl_req_valid`=0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_locate | input | 2 | Static search policy: 0 serial, 1 broadcast, 2 hybrid, 3 serial |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address, set index in the low bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Line was present |
| rsp_bank | output | 2 | Bank that served (3 on a miss) |
| rsp_lat | output | LAT_W | Cycles from acceptance to search verdict |
| rsp_data | output | DATA_W | Line data |
| nl_req_valid | output | 1 | Next-level fetch offered |
| nl_req_ready | input | 1 | Next level accepts the fetch |
| nl_req_addr | output | ADDR_W | Fetch address |
| nl_rsp_valid | input | 1 | Next-level data valid |
| nl_rsp_data | input | DATA_W | Next-level data |

## Verification
A wrong record of which bank holds a line does not show at the moment of the fault. It shows on the next access to that set, where `rsp_bank` and `rsp_lat` disagree with the position predicted by counting swaps since the fill. A stale or dropped line appears as a wrong `rsp_data`, or as an unexpected next-level request, within the following one or two requests. A fault in the search sequencing shows at once, as an `rsp_lat` that does not match the policy's latency series. A fault in the swap timing shows as `req_ready` returning one cycle too early or too late after the response pulse.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef enum logic [1:0] {
        LOC_SERIAL    = 2'd0,
        LOC_BROADCAST = 2'd1,
        LOC_HYBRID    = 2'd2,
        LOC_RSVD      = 2'd3
    } locate_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_DRAIN,
        ST_FETCH,
        ST_AWAIT,
        ST_INSERT,
        ST_SWAP_A,
        ST_PROMOTE
    } bsm_state_e;

    // Distance-dependent response delay of bank i
    function automatic int unsigned bank_delay(int unsigned i);
        return 2 + 2 * i;
    endfunction

endpackage

// File: rtl/bsm_bank.sv
module bsm_bank #(
    parameter int unsigned LATENCY = 2,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_valid,
    output logic              probe_ready,
    input  logic [IDX_W-1:0]  probe_idx,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_lvalid,
    output logic [TAG_W-1:0]  resp_tag,
    output logic [DATA_W-1:0] resp_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_lvalid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned SETS  = 1 << IDX_W;
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  ptag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_lvalid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            ptag_q <= '0;
        end else if (probe_valid && probe_ready) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LATENCY - 1);
            idx_q  <= probe_idx;
            ptag_q <= probe_tag;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign probe_ready = !busy_q;
    assign resp_valid  = busy_q && (cnt_q == '0);
    assign resp_lvalid = vld_q[idx_q];
    assign resp_tag    = tag_q[idx_q];
    assign resp_data   = data_q[idx_q];
    assign resp_hit    = resp_valid && resp_lvalid && (resp_tag == ptag_q);

endmodule

// File: rtl/bsm_launch.sv
module bsm_launch
    import bsm_pkg::*;
#(
    parameter int unsigned NBANK = 4,
    parameter int unsigned HYB_M = 2
) (
    input  locate_e          policy,
    input  logic             start,
    input  logic             searching,
    input  logic [NBANK-1:0] resp_valid,
    input  logic [NBANK-1:0] resp_hit,
    output logic [NBANK-1:0] launch
);
    int unsigned wave;

    // Number of banks probed at acceptance
    always_comb begin
        unique case (policy)
            LOC_BROADCAST: wave = NBANK;
            LOC_HYBRID:    wave = HYB_M;
            default:       wave = 1;
        endcase
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign launch[g] = start;
        end else begin : g_chain
            logic in_wave;
            assign in_wave   = (g < wave);
            assign launch[g] = (start && in_wave)
                             || (searching && !in_wave && resp_valid[g-1] && !resp_hit[g-1]);
        end
    end

endmodule

// File: rtl/bankset_migrator.sv
module bankset_migrator
    import bsm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NBANK  = 4,
    parameter int unsigned HYB_M  = 2,
    parameter int unsigned LAT_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_locate,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [$clog2(NBANK)-1:0] rsp_bank,
    output logic [LAT_W-1:0]         rsp_lat,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     nl_req_valid,
    input  logic                     nl_req_ready,
    output logic [ADDR_W-1:0]        nl_req_addr,
    input  logic                     nl_rsp_valid,
    input  logic [DATA_W-1:0]        nl_rsp_data
);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam int unsigned BI_W  = $clog2(NBANK);
    localparam logic [BI_W-1:0] FAR = BI_W'(NBANK - 1);

    bsm_state_e state_q, state_d;
    locate_e    policy;
    assign policy = locate_e'(cfg_locate);

    // request context
    logic [IDX_W-1:0]  req_idx_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic              req_wr_q;
    logic [DATA_W-1:0] req_wd_q;
    // lines seen during the search
    logic [NBANK-1:0]  lv_q;
    logic [TAG_W-1:0]  lt_q [NBANK];
    logic [DATA_W-1:0] ld_q [NBANK];
    logic [NBANK-1:0]  done_q, pend_q;
    logic [BI_W-1:0]   hit_bank_q;
    logic [DATA_W-1:0] hit_data_q, fill_q;
    logic [LAT_W-1:0]  lat_cnt_q, miss_lat_q;

    // bank-side wiring
    logic [NBANK-1:0]  launch, bank_ready, bank_rv, bank_rh, bank_rlv, wr_en;
    logic [TAG_W-1:0]  bank_rt [NBANK];
    logic [DATA_W-1:0] bank_rd [NBANK];
    logic [IDX_W-1:0]  probe_idx;
    logic [TAG_W-1:0]  probe_tag;
    logic              wr_lvalid;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    logic              accept, hit_now, all_done;
    logic [BI_W-1:0]   hit_idx, promo_dst;
    logic [NBANK-1:0]  pend_nxt;

    assign accept   = req_valid && req_ready;
    assign hit_now  = |(bank_rv & bank_rh);
    assign pend_nxt = (pend_q & ~bank_rv) | launch;
    assign all_done = &(done_q | bank_rv);
    assign promo_dst = (hit_bank_q == '0) ? '0 : BI_W'(hit_bank_q - 1'b1);

    always_comb begin
        hit_idx = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (bank_rv[i] && bank_rh[i]) hit_idx = BI_W'(i);
        end
    end

    assign probe_idx = (state_q == ST_IDLE) ? req_addr[IDX_W-1:0]      : req_idx_q;
    assign probe_tag = (state_q == ST_IDLE) ? req_addr[ADDR_W-1:IDX_W] : req_tag_q;

    bsm_launch #(.NBANK(NBANK), .HYB_M(HYB_M)) u_launch (
        .policy     (policy),
        .start      (accept),
        .searching  (state_q == ST_SEARCH),
        .resp_valid (bank_rv),
        .resp_hit   (bank_rh),
        .launch     (launch)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bsm_bank #(
            .LATENCY (bank_delay(g)),
            .IDX_W   (IDX_W),
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .probe_valid (launch[g]),
            .probe_ready (bank_ready[g]),
            .probe_idx   (probe_idx),
            .probe_tag   (probe_tag),
            .resp_valid  (bank_rv[g]),
            .resp_hit    (bank_rh[g]),
            .resp_lvalid (bank_rlv[g]),
            .resp_tag    (bank_rt[g]),
            .resp_data   (bank_rd[g]),
            .wr_en       (wr_en[g]),
            .wr_idx      (req_idx_q),
            .wr_lvalid   (wr_lvalid),
            .wr_tag      (wr_tag),
            .wr_data     (wr_data)
        );
    end

    function automatic bsm_state_e after_hit(logic [BI_W-1:0] hb, logic wr);
        if (hb != '0) return ST_SWAP_A;
        if (wr)       return ST_PROMOTE;
        return ST_IDLE;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (hit_now) begin
                    state_d = (pend_nxt != '0) ? ST_DRAIN : after_hit(hit_idx, req_wr_q);
                end else if (all_done) begin
                    state_d = req_wr_q ? ST_INSERT : ST_FETCH;
                end
            end
            ST_DRAIN:   if (pend_nxt == '0) state_d = after_hit(hit_bank_q, req_wr_q);
            ST_FETCH:   if (nl_req_ready) state_d = ST_AWAIT;
            ST_AWAIT:   if (nl_rsp_valid) state_d = ST_INSERT;
            ST_INSERT:  state_d = ST_IDLE;
            ST_SWAP_A:  state_d = ST_PROMOTE;
            ST_PROMOTE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and bank write commands
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        nl_req_valid = (state_q == ST_FETCH);
        nl_req_addr  = {req_tag_q, req_idx_q};
        wr_en        = '0;
        wr_lvalid    = 1'b1;
        wr_tag       = req_tag_q;
        wr_data      = fill_q;
        unique case (state_q)
            ST_SWAP_A: begin
                wr_en[hit_bank_q] = 1'b1;
                wr_lvalid = lv_q[BI_W'(hit_bank_q - 1'b1)];
                wr_tag    = lt_q[BI_W'(hit_bank_q - 1'b1)];
                wr_data   = ld_q[BI_W'(hit_bank_q - 1'b1)];
            end
            ST_PROMOTE: begin
                wr_en[promo_dst] = 1'b1;
                wr_data = hit_data_q;
            end
            ST_INSERT: wr_en[FAR] = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_idx_q  <= '0;
            req_tag_q  <= '0;
            req_wr_q   <= 1'b0;
            req_wd_q   <= '0;
            lv_q       <= '0;
            done_q     <= '0;
            pend_q     <= '0;
            hit_bank_q <= '0;
            hit_data_q <= '0;
            fill_q     <= '0;
            lat_cnt_q  <= '0;
            miss_lat_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_bank   <= '0;
            rsp_lat    <= '0;
            rsp_data   <= '0;
            for (int i = 0; i < NBANK; i++) begin
                lt_q[i] <= '0;
                ld_q[i] <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            pend_q    <= pend_nxt;
            for (int i = 0; i < NBANK; i++) begin
                if (bank_rv[i]) begin
                    lv_q[i] <= bank_rlv[i];
                    lt_q[i] <= bank_rt[i];
                    ld_q[i] <= bank_rd[i];
                end
            end
            if (accept) begin
                req_idx_q <= req_addr[IDX_W-1:0];
                req_tag_q <= req_addr[ADDR_W-1:IDX_W];
                req_wr_q  <= req_write;
                req_wd_q  <= req_wdata;
                done_q    <= '0;
                lat_cnt_q <= LAT_W'(1);
            end else begin
                done_q <= done_q | bank_rv;
                if (state_q == ST_SEARCH) lat_cnt_q <= lat_cnt_q + 1'b1;
            end
            if (state_q == ST_SEARCH && hit_now) begin
                hit_bank_q <= hit_idx;
                hit_data_q <= req_wr_q ? req_wd_q : bank_rd[hit_idx];
                rsp_valid  <= 1'b1;
                rsp_hit    <= 1'b1;
                rsp_bank   <= hit_idx;
                rsp_lat    <= lat_cnt_q;
                rsp_data   <= req_wr_q ? req_wd_q : bank_rd[hit_idx];
            end else if (state_q == ST_SEARCH && all_done) begin
                miss_lat_q <= lat_cnt_q;
                fill_q     <= req_wd_q;
            end
            if (state_q == ST_AWAIT && nl_rsp_valid) fill_q <= nl_rsp_data;
            if (state_q == ST_INSERT) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_bank  <= FAR;
                rsp_lat   <= miss_lat_q;
                rsp_data  <= fill_q;
            end
        end
    end

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker
    import bsm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NBANK  = 4,
    parameter int unsigned LAT_W  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input bsm_state_e               state,
    input logic [1:0]               cfg_locate,
    input logic                     req_ready,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic [$clog2(NBANK)-1:0] rsp_bank,
    input logic [LAT_W-1:0]         rsp_lat,
    input logic                     nl_req_valid,
    input logic                     nl_req_ready,
    input logic [ADDR_W-1:0]        nl_req_addr,
    input logic [NBANK-1:0]         launch,
    input logic [NBANK-1:0]         bank_ready,
    input logic [NBANK-1:0]         bank_rv,
    input logic [NBANK-1:0]         bank_rh,
    input logic [NBANK-1:0]         wr_en
);
    AST_PROBE_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (launch & ~bank_ready) == '0);  // R1

    AST_SERIAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locate == 2'd0) |-> $countones(launch) <= 1);  // R1

    AST_BCAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && cfg_locate == 2'd1) |-> rsp_lat == LAT_W'(2 + 2 * rsp_bank));  // R2

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_rv & bank_rh));  // R4

    AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP_A) |=> (state == ST_PROMOTE && $countones(wr_en) == 1));  // R4

    AST_MISS_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_bank == ($clog2(NBANK))'(NBANK - 1));  // R6

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_addr)));  // R6

    AST_NEAR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[NBANK-2:0] != '0) |-> (state == ST_SWAP_A || state == ST_PROMOTE));  // R7

    AST_SWAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_bank != '0) |-> !req_ready);  // R8

endmodule

bind bankset_migrator bsm_checker #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .LAT_W  (LAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .cfg_locate   (cfg_locate),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_bank     (rsp_bank),
    .rsp_lat      (rsp_lat),
    .nl_req_valid (nl_req_valid),
    .nl_req_ready (nl_req_ready),
    .nl_req_addr  (nl_req_addr),
    .launch       (launch),
    .bank_ready   (bank_ready),
    .bank_rv      (bank_rv),
    .bank_rh      (bank_rh),
    .wr_en        (wr_en)
);

// File: tb/bankset_migrator_test.sv
`timescale 1ns/1ps
module bankset_migrator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_locate = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_bank;
    logic [5:0]  rsp_lat;
    logic [15:0] rsp_data;
    logic        nl_req_valid;
    logic        nl_req_ready = 1'b1;
    logic [7:0]  nl_req_addr;
    logic        nl_rsp_valid = 1'b0;
    logic [15:0] nl_rsp_data = '0;

    int n_checks = 0;
    int n_errs   = 0;
    int mem_reqs = 0;
    logic [7:0] last_nl_addr = '0;

    always #2.5 clk = ~clk;

    bankset_migrator uut (
        .clk(clk), .rst_n(rst_n), .cfg_locate(cfg_locate),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bank(rsp_bank),
        .rsp_lat(rsp_lat), .rsp_data(rsp_data),
        .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready), .nl_req_addr(nl_req_addr),
        .nl_rsp_valid(nl_rsp_valid), .nl_rsp_data(nl_rsp_data)
    );

    // next-level memory: data = {~addr, addr}, answers 3 cycles after the handshake
    initial begin
        forever begin
            @(negedge clk);
            if (nl_req_valid) begin
                logic [7:0] a;
                a = nl_req_addr;
                last_nl_addr = a;
                mem_reqs++;
                repeat (3) @(negedge clk);
                nl_rsp_data  = {~a, a};
                nl_rsp_valid = 1'b1;
                @(negedge clk);
                nl_rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    logic        o_hit;
    logic [1:0]  o_bank;
    logic [5:0]  o_lat;
    logic [15:0] o_data;
    int          o_gap;

    task automatic run_req(input logic [1:0] pol, input logic wr,
                           input logic [7:0] addr, input logic [15:0] wd);
        int t;
        @(negedge clk);
        cfg_locate = pol;
        req_write  = wr;
        req_addr   = addr;
        req_wdata  = wd;
        req_valid  = 1'b1;
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        o_hit = 1'bx;
        while (t < 300) begin
            @(negedge clk);
            if (rsp_valid) begin
                o_hit = rsp_hit; o_bank = rsp_bank; o_lat = rsp_lat; o_data = rsp_data;
                break;
            end
            t++;
        end
        chk(t < 300, "R8", "response timeout", t, 0);
        o_gap = 0;
        while (!req_ready && o_gap < 100) begin @(negedge clk); o_gap++; end
    endtask

    typedef struct packed {
        logic [1:0]  pol;
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic        hit;
        logic [1:0]  bank;
        logic [5:0]  lat;
        logic [15:0] data;
        logic        mreq;
    } vec_t;

    // addresses: A=04 B=08 C=0C D=10 E=14 (set 0), 05 (set 1)
    localparam vec_t VEC [21] = '{
        '{2'd0, 1'b0, 8'h04, 16'h0000, 1'b0, 2'd3, 6'd20, 16'hFB04, 1'b1}, // R6 A fills bank3
        '{2'd0, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd3, 6'd20, 16'hFB04, 1'b0}, // R1 R4 A -> bank2
        '{2'd1, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd2, 6'd6,  16'hFB04, 1'b0}, // R2 R4 A -> bank1
        '{2'd2, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd1, 6'd4,  16'hFB04, 1'b0}, // R3 R4 A -> bank0
        '{2'd0, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd0, 6'd2,  16'hFB04, 1'b0}, // R1 R5 A stays
        '{2'd1, 1'b0, 8'h08, 16'h0000, 1'b0, 2'd3, 6'd8,  16'hF708, 1'b1}, // R2 R6 B miss
        '{2'd2, 1'b0, 8'h08, 16'h0000, 1'b1, 2'd3, 6'd18, 16'hF708, 1'b0}, // R3 B -> bank2
        '{2'd0, 1'b0, 8'h08, 16'h0000, 1'b1, 2'd2, 6'd12, 16'hF708, 1'b0}, // R1 B -> bank1
        '{2'd0, 1'b0, 8'h08, 16'h0000, 1'b1, 2'd1, 6'd6,  16'hF708, 1'b0}, // R4 B<->A
        '{2'd0, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd1, 6'd6,  16'hFB04, 1'b0}, // R4 displaced A in bank1
        '{2'd2, 1'b0, 8'h0C, 16'h0000, 1'b0, 2'd3, 6'd18, 16'hF30C, 1'b1}, // R3 R6 C miss
        '{2'd1, 1'b0, 8'h0C, 16'h0000, 1'b1, 2'd3, 6'd8,  16'hF30C, 1'b0}, // R2 C -> bank2
        '{2'd0, 1'b1, 8'h10, 16'h1234, 1'b0, 2'd3, 6'd20, 16'h1234, 1'b0}, // R9 write miss D
        '{2'd1, 1'b1, 8'h0C, 16'h5678, 1'b1, 2'd2, 6'd6,  16'h5678, 1'b0}, // R9 write hit C
        '{2'd1, 1'b0, 8'h0C, 16'h0000, 1'b1, 2'd1, 6'd4,  16'h5678, 1'b0}, // R9 R4 C -> bank0
        '{2'd0, 1'b0, 8'h14, 16'h0000, 1'b0, 2'd3, 6'd20, 16'hEB14, 1'b1}, // R7 E evicts D
        '{2'd0, 1'b0, 8'h10, 16'h0000, 1'b0, 2'd3, 6'd20, 16'hEF10, 1'b1}, // R7 D gone
        '{2'd1, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd1, 6'd4,  16'hFB04, 1'b0}, // R7 A untouched
        '{2'd1, 1'b0, 8'h08, 16'h0000, 1'b1, 2'd2, 6'd6,  16'hF708, 1'b0}, // R7 B untouched
        '{2'd3, 1'b0, 8'h05, 16'h0000, 1'b0, 2'd3, 6'd20, 16'hFA05, 1'b1}, // R10 R1 other set
        '{2'd0, 1'b0, 8'h0C, 16'h0000, 1'b1, 2'd2, 6'd12, 16'h5678, 1'b0}  // R10 R1 C in bank2
    };

    function automatic string tag_of(vec_t v);
        if (v.wr)       return "R9";
        if (!v.hit)     return "R6";
        if (v.pol == 1) return "R2";
        if (v.pol == 2) return "R3";
        return "R1";
    endfunction

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", rsp_valid, 0);
        chk(nl_req_valid == 1'b0, "R11", "nl_req_valid in reset", nl_req_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

        for (int k = 0; k < 21; k++) begin
            vec_t v;
            int m0;
            string tg;
            v  = VEC[k];
            tg = tag_of(v);
            m0 = mem_reqs;
            run_req(v.pol, v.wr, v.addr, v.wd);
            chk(o_hit === v.hit, tg, $sformatf("vec %0d hit", k), o_hit, v.hit);
            chk(o_bank === v.bank, tg, $sformatf("vec %0d bank", k), o_bank, v.bank);
            chk(o_lat === v.lat, tg, $sformatf("vec %0d lat", k), o_lat, v.lat);
            chk(o_data === v.data, tg, $sformatf("vec %0d data", k), o_data, v.data);
            chk((mem_reqs - m0) == int'(v.mreq), v.wr ? "R9" : "R6",
                $sformatf("vec %0d fetch count", k), mem_reqs - m0, v.mreq);
            if (v.mreq)
                chk(last_nl_addr == v.addr, "R6", "fetch address", last_nl_addr, v.addr);
            if (!v.hit || (v.hit && v.bank == 0 && !v.wr && v.pol == 0))
                chk(o_gap == 0, "R8", $sformatf("vec %0d ready gap", k), o_gap, 0);
        end

        // R8: swap holds the set two cycles after the response
        run_req(2'd0, 1'b0, 8'h0C, 16'h0);   // C bank2 -> bank1 after table? C now bank1
        chk(o_bank == 2'd1 && o_lat == 6'd6, "R4", "C promoted into bank1", {o_bank, o_lat}, {2'd1, 6'd6});
        chk(o_gap == 2, "R8", "ready gap after swap", o_gap, 2);
        run_req(2'd0, 1'b0, 8'h0C, 16'h0);
        chk(o_bank == 2'd0 && o_lat == 6'd2, "R5", "C now in bank0", {o_bank, o_lat}, {2'd0, 6'd2});
        chk(o_gap == 0, "R8", "ready gap bank0 hit", o_gap, 0);
        run_req(2'd0, 1'b0, 8'h0C, 16'h0);
        chk(o_bank == 2'd0 && o_data == 16'h5678, "R5", "C stays in bank0", {o_bank, o_data}, {2'd0, 16'h5678});

        // R11: mid-run reset invalidates all lines
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "ready/rsp in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        begin
            int m0;
            m0 = mem_reqs;
            run_req(2'd1, 1'b0, 8'h0C, 16'h0);
            chk(o_hit == 1'b0 && o_lat == 6'd8, "R11", "line lost after reset", {o_hit, o_lat}, {1'b0, 6'd8});
            chk(o_data == 16'hF30C && mem_reqs - m0 == 1, "R6", "refetch after reset", o_data, 16'hF30C);
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule